// File: doc/BRIEF.md
# Lattice Row Transfer Controller

This block moves the state of a cellular-automaton lattice between two byte-wide memories and a cell array that shifts one whole row at a time. To fill the lattice, it reads an input memory one byte per cycle. A serial-in register assembles each row of COLS×CBITS bits from those bytes. When the row is complete, the controller pushes it into the top of the array, and the rows already there move down by one. To read the lattice out, it captures the bottom row into a parallel-in register and writes that row to an output memory one byte per cycle. During a readout the bottom row is fed back into the top, so after all rows have passed the lattice holds the same state as before.

A sequencer runs each operation in a fixed order: load, then iterate, then read. In run-through mode the array iterates n times and is read once at the end. In step mode the array iterates once, the whole lattice is read, and the controller waits for a continue pulse. This repeats until n iterations are done, and each readout overwrites the last one from address zero. The cell rule itself lives outside this block; it only sees the iterate enable.

Top module: `ca_row_xfer`

## Requirements
- R1: After reset the block is idle. busy, load_done, iter_done, in_rd_en, out_wr_en, arr_load and arr_iter are all 0, and rd_rows is 0.
- R2: During a load, in_rd_en is high for exactly ROWS×STG cycles, where STG = COLS×CBITS/8. The addresses run 0, 1, 2 … one per byte. Read data arrives one cycle after its request. Byte j of a row fills bits [8j+7:8j] of that row.
- R3: load_done rises 1 + STG×(ROWS+1) cycles after the cycle that accepts start. The first row read from memory ends up as the bottom row of the array.
- R4: A readout writes bytes to out_addr 0, 1, 2 … Rows go out bottom row first, and within a row the lowest byte goes first. The array holds its pre-read contents once the readout ends.
- R5: A readout takes ROWS×(1+STG) cycles. No byte is written on a row-capture cycle, so the output register is empty before each new capture.
- R6: In run-through mode (step_mode=0) arr_iter is high for exactly n cycles after the load, and then one readout follows. iter_done rises when that readout ends.
- R7: In step mode (step_mode=1) each iteration is one arr_iter cycle followed by a full readout. The block then waits, with no writes and busy held high, until cont is pulsed. After n iterations it goes idle with iter_done set.
- R8: A start pulse while busy is ignored. The running operation keeps its mode and count.
- R9: With n_iter=0 no iteration happens, and a single readout follows the load.
- R10: arr_load and arr_iter are never high together, and in_rd_en and out_wr_en are never high together.
- R11: rd_rows counts the rows written out in the current readout and reaches ROWS at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load/iterate/read operation when idle |
| step_mode | input | 1 | 1 = step mode, 0 = run-through; sampled with start |
| cont | input | 1 | Continue pulse while waiting in step mode |
| n_iter | input | ITER_W | Iteration count; sampled with start |
| in_rd_en | output | 1 | Input memory read request |
| in_addr | output | AW | Input memory byte address |
| in_rdata | input | 8 | Input memory data, one cycle after the request |
| out_wr_en | output | 1 | Output memory write strobe |
| out_addr | output | AW | Output memory byte address |
| out_wdata | output | 8 | Output memory write data |
| arr_load | output | 1 | Shift array rows down and take arr_top_in as the new top row |
| arr_iter | output | 1 | Apply the cell rule for one step |
| arr_top_in | output | COLS×CBITS | Row entering the top of the array |
| arr_bot_in | input | COLS×CBITS | Current bottom row of the array |
| busy | output | 1 | Operation in progress |
| load_done | output | 1 | Set when the load phase has finished |
| iter_done | output | 1 | Set when the last iteration has been read out |
| rd_rows | output | RCW | Rows written out in the current readout |

## Verification
The lattice is first filled with a ramp in which every byte differs. This exposes any swapped byte order, wrong row order, off-by-one address or lost byte. A lattice of all-ones bytes with one iteration of an increment rule makes every row wrap to zero, so a readout is only right if every row actually passed through the array once. A zero-iteration run and a step-mode run with pauses separate the read-only path from the iterate-then-read paths. Those pauses also show that nothing is written while the block waits. A start pulse sent in the middle of a load shows whether the latched mode and count can be disturbed.

// File: rtl/ca_xfer_pkg.sv
package ca_xfer_pkg;
  typedef enum logic [2:0] {
    XS_IDLE,
    XS_LOAD,
    XS_ITER,
    XS_READ,
    XS_HOLD
  } xfer_st_e;
endpackage

// File: rtl/ca_row_sipo.sv
module ca_row_sipo #(
  parameter int ROW_W = 16,
  localparam int STG = ROW_W / 8,
  localparam int CW  = $clog2(STG + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             take,
  input  logic [7:0]       din,
  output logic [ROW_W-1:0] row_q
);
  logic [ROW_W-1:0] row_d;

  generate
    if (STG == 1) begin : g_one
      always_comb row_d = din;
    end else begin : g_many
      always_comb row_d = {din, row_q[ROW_W-1:8]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else if (shift_en) row_q <= row_d;
  end

  // checker: bytes shifted in since the last row hand-off
  logic [CW-1:0] fill_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else if (take) fill_q <= shift_en ? CW'(1) : '0;
    else if (shift_en && fill_q <= CW'(STG)) fill_q <= fill_q + CW'(1);
  end

  assert_full_row_on_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> fill_q == CW'(STG));
endmodule

// File: rtl/ca_row_piso.sv
module ca_row_piso #(
  parameter int ROW_W = 16,
  localparam int STG = ROW_W / 8,
  localparam int CW  = $clog2(STG + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             shift_en,
  input  logic [ROW_W-1:0] din,
  output logic [7:0]       dout
);
  logic [ROW_W-1:0] q;
  logic [ROW_W-1:0] q_d;

  generate
    if (STG == 1) begin : g_one
      always_comb q_d = cap ? din : q;
    end else begin : g_many
      always_comb q_d = cap ? din : {8'h00, q[ROW_W-1:8]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (cap || shift_en) q <= q_d;
  end

  assign dout = q[7:0];

  // checker: bytes still waiting to leave the register
  logic [CW-1:0] left_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else if (cap) left_q <= CW'(STG);
    else if (shift_en && left_q != '0) left_q <= left_q - CW'(1);
  end

  assert_no_overread_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> left_q != '0);
  assert_empty_before_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> left_q == '0);
endmodule

// File: rtl/ca_xfer_fsm.sv
module ca_xfer_fsm
  import ca_xfer_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int STG    = 2,
  parameter int ITER_W = 8,
  localparam int NBYTES = ROWS * STG,
  localparam int AW     = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int SW     = (STG > 1) ? $clog2(STG) : 1,
  localparam int RCW    = $clog2(ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step_mode,
  input  logic              cont,
  input  logic [ITER_W-1:0] n_iter,
  output logic              in_rd_en,
  output logic [AW-1:0]     in_addr,
  output logic              sipo_shift,
  output logic              row_take,
  output logic              read_mode,
  output logic              piso_cap,
  output logic              piso_shift,
  output logic              out_wr_en,
  output logic [AW-1:0]     out_addr,
  output logic              arr_iter,
  output logic              busy,
  output logic              load_done,
  output logic              iter_done,
  output logic [RCW-1:0]    rd_rows
);
  xfer_st_e          st, st_d;
  logic              prime, prime_d;
  logic [SW-1:0]     stg, stg_d;
  logic [RCW-1:0]    rows, rows_d;
  logic [AW:0]       raddr, raddr_d;
  logic [AW-1:0]     waddr, waddr_d;
  logic [ITER_W-1:0] itc, itc_d;
  logic [ITER_W-1:0] n_q, n_d;
  logic              mode_q, mode_d;
  logic              ld_q, ld_d;
  logic              itd_q, itd_d;
  logic              rcap, rcap_d;
  logic [RCW-1:0]    rrows, rrows_d;

  wire last_stg = (stg == SW'(STG - 1));

  // output decode
  always_comb begin
    in_rd_en   = (st == XS_LOAD) && (raddr < (AW+1)'(NBYTES));
    sipo_shift = (st == XS_LOAD) && !prime && (rows < RCW'(ROWS));
    row_take   = (st == XS_LOAD) && !prime && (stg == '0) && (rows != '0);
    read_mode  = (st == XS_READ);
    piso_cap   = (st == XS_READ) && rcap;
    piso_shift = (st == XS_READ) && !rcap;
    out_wr_en  = piso_shift;
    arr_iter   = (st == XS_ITER);
  end

  assign in_addr   = raddr[AW-1:0];
  assign out_addr  = waddr;
  assign busy      = (st != XS_IDLE);
  assign load_done = ld_q;
  assign iter_done = itd_q;
  assign rd_rows   = rrows;

  // next-state logic
  always_comb begin
    st_d    = st;
    prime_d = prime;
    stg_d   = stg;
    rows_d  = rows;
    raddr_d = raddr;
    waddr_d = waddr;
    itc_d   = itc;
    n_d     = n_q;
    mode_d  = mode_q;
    ld_d    = ld_q;
    itd_d   = itd_q;
    rcap_d  = rcap;
    rrows_d = rrows;
    unique case (st)
      XS_IDLE: begin
        if (start) begin
          st_d    = XS_LOAD;
          prime_d = 1'b1;
          stg_d   = '0;
          rows_d  = '0;
          raddr_d = '0;
          itc_d   = '0;
          n_d     = n_iter;
          mode_d  = step_mode;
          ld_d    = 1'b0;
          itd_d   = 1'b0;
          rrows_d = '0;
        end
      end
      XS_LOAD: begin
        if (in_rd_en) raddr_d = raddr + (AW+1)'(1);
        if (prime) begin
          prime_d = 1'b0;
        end else if (last_stg) begin
          stg_d = '0;
          if (rows == RCW'(ROWS)) begin
            ld_d = 1'b1;
            if (n_q == '0) begin
              st_d = XS_READ; rcap_d = 1'b1; rows_d = '0; waddr_d = '0; rrows_d = '0;
            end else begin
              st_d = XS_ITER; rows_d = '0;
            end
          end else begin
            rows_d = rows + RCW'(1);
          end
        end else begin
          stg_d = stg + SW'(1);
        end
      end
      XS_ITER: begin
        itc_d = itc + ITER_W'(1);
        if (mode_q || (itc + ITER_W'(1) == n_q)) begin
          st_d = XS_READ; rcap_d = 1'b1; stg_d = '0; rows_d = '0; waddr_d = '0; rrows_d = '0;
        end
      end
      XS_READ: begin
        if (rcap) begin
          rcap_d = 1'b0;
        end else begin
          waddr_d = waddr + AW'(1);
          if (last_stg) begin
            stg_d   = '0;
            rcap_d  = 1'b1;
            rrows_d = rrows + RCW'(1);
            if (rows == RCW'(ROWS - 1)) begin
              rows_d = '0;
              if (mode_q && (itc != n_q)) st_d = XS_HOLD;
              else begin
                st_d  = XS_IDLE;
                itd_d = 1'b1;
              end
            end else begin
              rows_d = rows + RCW'(1);
            end
          end else begin
            stg_d = stg + SW'(1);
          end
        end
      end
      XS_HOLD: begin
        if (cont) st_d = XS_ITER;
      end
      default: st_d = XS_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= XS_IDLE;
      prime <= 1'b0;
      stg   <= '0;
      rows  <= '0;
      raddr <= '0;
      waddr <= '0;
      itc   <= '0;
      n_q   <= '0;
      mode_q <= 1'b0;
      ld_q  <= 1'b0;
      itd_q <= 1'b0;
      rcap  <= 1'b0;
      rrows <= '0;
    end else begin
      st    <= st_d;
      prime <= prime_d;
      stg   <= stg_d;
      rows  <= rows_d;
      raddr <= raddr_d;
      waddr <= waddr_d;
      itc   <= itc_d;
      n_q   <= n_d;
      mode_q <= mode_d;
      ld_q  <= ld_d;
      itd_q <= itd_d;
      rcap  <= rcap_d;
      rrows <= rrows_d;
    end
  end

  assert_mem_ports_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_rd_en && out_wr_en));
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd_en && $past(in_rd_en)) |-> in_addr == $past(in_addr) + AW'(1));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(mode_q) && $stable(n_q)));
  assert_iter_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_iter |-> itc < n_q);
  assert_hold_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XS_HOLD && !cont) |=> (st == XS_HOLD && !out_wr_en));
endmodule

// File: rtl/ca_row_xfer.sv
module ca_row_xfer #(
  parameter int COLS   = 8,
  parameter int CBITS  = 2,
  parameter int ROWS   = 4,
  parameter int ITER_W = 8,
  localparam int ROW_W  = COLS * CBITS,
  localparam int STG    = ROW_W / 8,
  localparam int NBYTES = ROWS * STG,
  localparam int AW     = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int RCW    = $clog2(ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step_mode,
  input  logic              cont,
  input  logic [ITER_W-1:0] n_iter,
  output logic              in_rd_en,
  output logic [AW-1:0]     in_addr,
  input  logic [7:0]        in_rdata,
  output logic              out_wr_en,
  output logic [AW-1:0]     out_addr,
  output logic [7:0]        out_wdata,
  output logic              arr_load,
  output logic              arr_iter,
  output logic [ROW_W-1:0]  arr_top_in,
  input  logic [ROW_W-1:0]  arr_bot_in,
  output logic              busy,
  output logic              load_done,
  output logic              iter_done,
  output logic [RCW-1:0]    rd_rows
);
  logic             sipo_shift, row_take, read_mode, piso_cap, piso_shift;
  logic [ROW_W-1:0] sipo_row;

  ca_xfer_fsm #(.ROWS(ROWS), .STG(STG), .ITER_W(ITER_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .step_mode(step_mode), .cont(cont),
    .n_iter(n_iter), .in_rd_en(in_rd_en), .in_addr(in_addr), .sipo_shift(sipo_shift),
    .row_take(row_take), .read_mode(read_mode), .piso_cap(piso_cap),
    .piso_shift(piso_shift), .out_wr_en(out_wr_en), .out_addr(out_addr),
    .arr_iter(arr_iter), .busy(busy), .load_done(load_done), .iter_done(iter_done),
    .rd_rows(rd_rows)
  );

  ca_row_sipo #(.ROW_W(ROW_W)) u_sipo (
    .clk(clk), .rst_n(rst_n), .shift_en(sipo_shift), .take(row_take),
    .din(in_rdata), .row_q(sipo_row)
  );

  ca_row_piso #(.ROW_W(ROW_W)) u_piso (
    .clk(clk), .rst_n(rst_n), .cap(piso_cap), .shift_en(piso_shift),
    .din(arr_bot_in), .dout(out_wdata)
  );

  // boundary redirect: during readout the bottom row wraps to the top
  assign arr_top_in = read_mode ? arr_bot_in : sipo_row;
  assign arr_load   = row_take | piso_cap;

  assert_load_iter_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_load && arr_iter));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(in_rd_en || out_wr_en || arr_load || arr_iter));
endmodule

// File: tb/test_ca_row_xfer.sv
module test_ca_row_xfer;
  localparam int COLS = 8, CBITS = 2, ROWS = 4, ITER_W = 8;
  localparam int ROW_W = COLS * CBITS;
  localparam int STG = ROW_W / 8;
  localparam int NB = ROWS * STG;
  localparam int AW = $clog2(NB);
  localparam int RCW = $clog2(ROWS + 1);
  localparam int LOAD_CYC = 1 + STG * (ROWS + 1);
  localparam int READ_CYC = ROWS * (1 + STG);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, step_mode, cont;
  logic [ITER_W-1:0] n_iter;
  logic in_rd_en, out_wr_en, arr_load, arr_iter, busy, load_done, iter_done;
  logic [AW-1:0] in_addr, out_addr;
  logic [7:0] in_rdata, out_wdata;
  logic [ROW_W-1:0] arr_top_in, arr_bot_in;
  logic [RCW-1:0] rd_rows;

  ca_row_xfer #(.COLS(COLS), .CBITS(CBITS), .ROWS(ROWS), .ITER_W(ITER_W)) i_ca_row_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .step_mode(step_mode), .cont(cont),
    .n_iter(n_iter), .in_rd_en(in_rd_en), .in_addr(in_addr), .in_rdata(in_rdata),
    .out_wr_en(out_wr_en), .out_addr(out_addr), .out_wdata(out_wdata),
    .arr_load(arr_load), .arr_iter(arr_iter), .arr_top_in(arr_top_in),
    .arr_bot_in(arr_bot_in), .busy(busy), .load_done(load_done),
    .iter_done(iter_done), .rd_rows(rd_rows)
  );

  // environment models: input memory and a row array with an increment rule
  logic [7:0] mem [NB];
  logic [ROW_W-1:0] arr [ROWS];
  always @(posedge clk) if (in_rd_en) in_rdata <= mem[in_addr];
  always @(posedge clk) begin
    if (arr_load) begin
      arr[0] <= arr_top_in;
      for (int i = 1; i < ROWS; i++) arr[i] <= arr[i-1];
    end else if (arr_iter) begin
      for (int i = 0; i < ROWS; i++) arr[i] <= arr[i] + ROW_W'(1);
    end
  end
  assign arr_bot_in = arr[ROWS-1];

  int ntot = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // scoreboard
  int exp_addr_q[$];
  int exp_data_q[$];
  int rd_idx;
  int nreads;

  always @(negedge clk) begin
    if (rst_n && out_wr_en) begin
      if (exp_addr_q.size() == 0) chk(0, "R7", "unexpected write", int'(out_addr), -1);
      else begin
        int ea, ed;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        chk(int'(out_addr) == ea, "R4", "write address", out_addr, ea);
        chk(int'(out_wdata) == ed, "R4", "write data", out_wdata, ed);
      end
    end
    if (rst_n && in_rd_en) begin
      chk(int'(in_addr) == rd_idx, "R2", "read address", in_addr, rd_idx);
      rd_idx++;
      nreads++;
    end
  end

  function automatic logic [ROW_W-1:0] mem_row(input int m);
    logic [ROW_W-1:0] v;
    for (int j = 0; j < STG; j++) v[8*j +: 8] = mem[m*STG + j];
    return v;
  endfunction

  task automatic push_pass(input int k);
    for (int m = 0; m < ROWS; m++) begin
      logic [ROW_W-1:0] v;
      v = mem_row(m) + ROW_W'(k);
      for (int j = 0; j < STG; j++) begin
        exp_addr_q.push_back(m*STG + j);
        exp_data_q.push_back(int'(v[8*j +: 8]));
      end
    end
  endtask

  task automatic check_array(input int k, input string req);
    for (int m = 0; m < ROWS; m++) begin
      logic [ROW_W-1:0] e;
      e = mem_row(m) + ROW_W'(k);
      chk(arr[ROWS-1-m] == e, req, "array row", arr[ROWS-1-m], e);
    end
  endtask

  // one full operation; poke=1 sends a stray start during the load
  task automatic run_op(input bit stp, input int n, input bit poke);
    int cnt;
    if (stp && n > 0) for (int k = 1; k <= n; k++) push_pass(k);
    else push_pass(n);
    rd_idx = 0;
    nreads = 0;
    @(negedge clk);
    start = 1'b1; step_mode = stp; n_iter = ITER_W'(n);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!load_done && cnt < 1000) begin
      if (poke && cnt == 4) begin
        start = 1'b1; step_mode = ~stp; n_iter = 8'd7; cont = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; cont = 1'b0;
      cnt++;
    end
    chk(cnt == LOAD_CYC, "R3", "load cycles", cnt, LOAD_CYC);
    chk(nreads == NB, "R2", "byte reads", nreads, NB);
    check_array(0, "R3");
    if (!stp || n == 0) begin
      cnt = 0;
      while (!iter_done && cnt < 1000) begin @(negedge clk); cnt++; end
      if (n == 0) chk(cnt == READ_CYC, "R9", "read-only cycles", cnt, READ_CYC);
      else chk(cnt == n + READ_CYC, "R6", "iterate+read cycles", cnt, n + READ_CYC);
      chk(rd_rows == RCW'(ROWS), "R11", "rows read", rd_rows, ROWS);
      check_array(n, "R4");
    end else begin
      for (int p = 1; p <= n; p++) begin
        cnt = 0;
        while (!(rd_rows == RCW'(ROWS) && exp_addr_q.size() <= (n-p)*NB) && cnt < 1000) begin
          @(negedge clk); cnt++;
        end
        chk(exp_addr_q.size() == (n-p)*NB, "R7", "pass writes left", exp_addr_q.size(), (n-p)*NB);
        check_array(p, "R7");
        if (p < n) begin
          repeat (5) @(negedge clk);
          chk(busy == 1'b1, "R7", "busy while waiting", busy, 1);
          chk(iter_done == 1'b0, "R7", "not done while waiting", iter_done, 0);
          cont = 1'b1;
          @(negedge clk);
          cont = 1'b0;
          cnt = 0;
          while (rd_rows == RCW'(ROWS) && cnt < 10) begin @(negedge clk); cnt++; end
        end
      end
      @(negedge clk);
      chk(busy == 1'b0, "R7", "idle after last pass", busy, 0);
      chk(iter_done == 1'b1, "R7", "iter_done after last pass", iter_done, 1);
    end
    chk(exp_addr_q.size() == 0, "R5", "all expected bytes written", exp_addr_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    nfail++; ntot++;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; step_mode = 1'b0; cont = 1'b0; n_iter = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && load_done == 0 && iter_done == 0, "R1", "reset flags",
        {busy, load_done, iter_done}, 0);
    chk(in_rd_en == 0 && out_wr_en == 0 && arr_load == 0 && arr_iter == 0, "R1",
        "reset strobes", {in_rd_en, out_wr_en, arr_load, arr_iter}, 0);
    chk(rd_rows == 0, "R1", "reset rd_rows", rd_rows, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // ramp pattern, run-through, stray start during load (R2 R3 R4 R5 R6 R8 R11)
    for (int i = 0; i < NB; i++) mem[i] = 8'(8'h11 * (i + 1) + i);
    run_op(1'b0, 3, 1'b1);
    chk(iter_done == 1'b1 && busy == 1'b0, "R8", "stray start left no effect",
        {iter_done, busy}, 2);

    // zero iterations (R9)
    for (int i = 0; i < NB; i++) mem[i] = 8'(8'hA0 + 3 * i);
    run_op(1'b0, 0, 1'b0);

    // all-ones bytes, one iteration wraps every row (R6)
    for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
    run_op(1'b0, 1, 1'b0);

    // step mode, three iterations (R7)
    for (int i = 0; i < NB; i++) mem[i] = 8'(8'h5C ^ (i * 8'h17));
    run_op(1'b1, 3, 1'b0);

    // step mode with zero iterations behaves as a single readout (R9)
    run_op(1'b1, 0, 1'b0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule